// File: doc/BRIEF.md
# Two-Bank Edge and Level Interrupt Collector

This block collects up to sixty-four interrupt lines, arranged as two banks of thirty-two, and combines them into one request toward the processor. Each source has an enable bit and an event latch. The event latch records a rising line, but only when that source is enabled at the moment of the rise. A fixed per-bank parameter marks some sources as level-type. A level-type source asserts the request for as long as its line is high and it is enabled, whether or not an event was latched. Software finds the source by reading the event and raw-level registers and scanning the bits. It clears an event by writing ones to the acknowledge register.

Registers are reached through a simple synchronous bus with word addresses. The bank for sources 0 to 31 sits above the bank for sources 32 to 63 in the address window. The register interface is a two-state machine: `ST_IDLE` waits for an access. A read moves it to `ST_RESP` (transition *read-accept*). In `ST_RESP` the read data is presented for one cycle. It then either returns to `ST_IDLE` (*response-done*) or stays in `ST_RESP` when another read arrives (*read-chain*). A write never leaves `ST_IDLE` (*write-absorb*).

Top module: `irqc_top`

## Requirements
- R1: After reset every event latch and every enable bit is zero and `irq_req` is low.
- R2: The address map uses word addresses. Bank 0 (sources 0..31) occupies word addresses 8..11 (byte 0x20) and bank 1 (sources 32..63) occupies words 4..7 (byte 0x10). Inside a bank, offset 0 is event, 1 is enable, 2 is acknowledge and 3 is level. Source n is bit n%32 of bank n/32. Data is little-endian: data bit k is source bit k, and byte lane 0 holds bits 7:0.
- R3: A line that rises while its enable bit is already set sets its event bit at the next clock edge.
- R4: Setting an enable bit while the line is already high sets no event bit and, for an edge-type source, raises no request.
- R5: Writing the acknowledge register clears the event bits written as 1 and leaves the bits written as 0 unchanged. A new rise in the same cycle as its own acknowledge keeps the event bit set.
- R6: Reading the level register returns the present raw state of the bank's lines, whatever the enables are.
- R7: A level-type source requests while its line is high and it is enabled, even with no event latched. The default level-type masks are 0x3FF00000 for bank 0 and 0x1FF00000 for bank 1.
- R8: `irq_req` is the OR over both banks of (event AND enable) OR (line AND level-mask AND enable). Clearing an enable removes its request and leaves the event bit latched.
- R9: Reading the enable register returns exactly the last value written to it.
- R10: The following have no effect on any state: writes to the event and level registers, and any access to word addresses outside the two banks. Reads of those addresses return zero, and so do reads of the acknowledge register.
- R11: Read data appears on `bus_rdata` with `bus_rvalid` high in the cycle right after the request cycle, and `bus_rvalid` is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address inside the 64-byte window |
| bus_wdata | input | 32 | Write data, little-endian |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| irq_lines | input | 64 | Interrupt source lines, synchronous to clk |
| irq_req | output | 1 | Combined interrupt request |

## Verification
A register write takes effect at the clock edge that samples it. The enable and event state can be read back through a read issued on the next cycle, and that read returns its data one cycle later. A line change is latched at the first edge after it is driven. `irq_req` then follows that registered state combinationally; for level-type sources it also follows the raw line directly. The bench drives at the falling edge and samples `irq_req` one full cycle after each stimulus. A scoreboard queue holds the value expected from each read. A falling-edge monitor pops the queue exactly when `bus_rvalid` rises, so a late, early or spurious response is reported as well as a wrong value.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned SRC_PER_BANK = 32;

    typedef enum logic [1:0] {
        REG_EVENT  = 2'd0,
        REG_ENABLE = 2'd1,
        REG_ACK    = 2'd2,
        REG_LEVEL  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
#(
    parameter int unsigned       WIDTH    = SRC_PER_BANK,
    parameter logic [WIDTH-1:0]  LVL_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lines,
    input  logic             en_we,
    input  logic             ack_we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] ev_q,
    output logic [WIDTH-1:0] en_q,
    output logic             req
);

    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] rise;
    logic [WIDTH-1:0] ack_bits;
    logic [WIDTH-1:0] ev_d;
    logic [WIDTH-1:0] en_d;

    always_comb begin
        rise     = lines & ~prev_q & en_q;
        ack_bits = ack_we ? wdata : '0;
        ev_d     = (ev_q & ~ack_bits) | rise;
        en_d     = en_we ? wdata : en_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            ev_q   <= '0;
            en_q   <= '0;
        end else begin
            prev_q <= lines;
            ev_q   <= ev_d;
            en_q   <= en_d;
        end
    end

    always_comb begin
        req = |((ev_q | (lines & LVL_MASK)) & en_q);
    end

    // R3
    ev_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev_q & ~$past(ev_q)) & ~($past(en_q) & $past(lines) & ~$past(prev_q))) == '0);

    // R5
    ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ack_we) |->
            ((ev_q & $past(wdata) & ~($past(en_q) & $past(lines) & ~$past(prev_q))) == '0));

    // R9
    en_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_we) |-> (en_q == $past(wdata)));

    // R10
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_we) |-> $stable(en_q));

endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
    import irqc_pkg::*;
#(
    parameter int unsigned BANKS = 2,
    parameter int unsigned AW    = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_sel,
    input  logic                           bus_wr,
    input  logic [AW-1:0]                  bus_addr,
    input  logic [BANKS*SRC_PER_BANK-1:0]  ev_flat,
    input  logic [BANKS*SRC_PER_BANK-1:0]  en_flat,
    input  logic [BANKS*SRC_PER_BANK-1:0]  lines,
    output logic [BANKS-1:0]               en_we,
    output logic [BANKS-1:0]               ack_we,
    output logic [SRC_PER_BANK-1:0]        bus_rdata,
    output logic                           bus_rvalid
);

    localparam int unsigned SLOT_W = AW - 2;

    logic [SLOT_W-1:0] slot;
    reg_sel_e          rsel;
    logic [BANKS-1:0]  hit;
    logic              rd_req;
    logic              wr_req;
    logic [SRC_PER_BANK-1:0] rd_word;
    logic [SRC_PER_BANK-1:0] rdata_q;
    bus_state_e        state_q;
    bus_state_e        state_d;

    assign slot   = bus_addr[AW-1:2];
    assign rsel   = reg_sel_e'(bus_addr[1:0]);
    assign rd_req = bus_sel & ~bus_wr;
    assign wr_req = bus_sel & bus_wr;

    // lower-numbered bank sits at the higher slot
    for (genvar b = 0; b < BANKS; b++) begin : g_dec
        localparam logic [SLOT_W-1:0] SLOT_ID = SLOT_W'(BANKS - b);
        assign hit[b]    = (slot == SLOT_ID);
        assign en_we[b]  = wr_req & hit[b] & (rsel == REG_ENABLE);
        assign ack_we[b] = wr_req & hit[b] & (rsel == REG_ACK);
    end

    always_comb begin
        rd_word = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (hit[b]) begin
                unique case (rsel)
                    REG_EVENT:  rd_word = ev_flat[b*SRC_PER_BANK +: SRC_PER_BANK];
                    REG_ENABLE: rd_word = en_flat[b*SRC_PER_BANK +: SRC_PER_BANK];
                    REG_ACK:    rd_word = '0;
                    REG_LEVEL:  rd_word = lines[b*SRC_PER_BANK +: SRC_PER_BANK];
                endcase
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = rd_req ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_req ? ST_RESP : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_req) begin
            rdata_q <= rd_word;
        end
    end

    assign bus_rvalid = (state_q == ST_RESP);
    assign bus_rdata  = rdata_q;

    // R11
    rvalid_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);

    // R11
    rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !bus_rvalid);

    // R10
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (hit == '0)) |=> (bus_rdata == '0));

    // R10
    wr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({en_we, ack_we}));

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned                      BANKS    = 2,
    parameter logic [BANKS*SRC_PER_BANK-1:0]    LVL_MASK = {32'h1FF0_0000, 32'h3FF0_0000},
    parameter int unsigned                      AW       = $clog2((BANKS + 2) * 4)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_sel,
    input  logic                           bus_wr,
    input  logic [AW-1:0]                  bus_addr,
    input  logic [SRC_PER_BANK-1:0]        bus_wdata,
    output logic [SRC_PER_BANK-1:0]        bus_rdata,
    output logic                           bus_rvalid,
    input  logic [BANKS*SRC_PER_BANK-1:0]  irq_lines,
    output logic                           irq_req
);

    localparam int unsigned NSRC = BANKS * SRC_PER_BANK;

    logic [NSRC-1:0]  ev_flat;
    logic [NSRC-1:0]  en_flat;
    logic [BANKS-1:0] en_we;
    logic [BANKS-1:0] ack_we;
    logic [BANKS-1:0] bank_req;

    irqc_regif #(
        .BANKS (BANKS),
        .AW    (AW)
    ) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .ev_flat    (ev_flat),
        .en_flat    (en_flat),
        .lines      (irq_lines),
        .en_we      (en_we),
        .ack_we     (ack_we),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid)
    );

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        irqc_bank #(
            .WIDTH    (SRC_PER_BANK),
            .LVL_MASK (LVL_MASK[b*SRC_PER_BANK +: SRC_PER_BANK])
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .lines  (irq_lines[b*SRC_PER_BANK +: SRC_PER_BANK]),
            .en_we  (en_we[b]),
            .ack_we (ack_we[b]),
            .wdata  (bus_wdata),
            .ev_q   (ev_flat[b*SRC_PER_BANK +: SRC_PER_BANK]),
            .en_q   (en_flat[b*SRC_PER_BANK +: SRC_PER_BANK]),
            .req    (bank_req[b])
        );
    end

    assign irq_req = |bank_req;

    // R8
    no_enable_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_flat == '0) |-> !irq_req);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> ((ev_flat == '0) && (en_flat == '0)));

endmodule

// File: tb/irqc_top_test.sv
module irqc_top_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel;
    logic        bus_wr;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [63:0] src;
    logic        irq_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    irqc_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .irq_lines  (src),
        .irq_req    (irq_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per response
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected rvalid", 32'h1, 32'h0);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_src(input int idx, input logic v);
        @(negedge clk);
        src[idx] = v;
    endtask

    task automatic chk_irq(input string tag, input logic e);
        @(negedge clk);
        check(tag, {31'b0, irq_req}, {31'b0, e});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; src = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_irq("R1 irq after reset", 1'b0);
        bus_read(4'd9, 32'h0, "R1 bank0 enable");
        bus_read(4'd5, 32'h0, "R1 bank1 enable");
        bus_read(4'd8, 32'h0, "R1 bank0 event");

        // R3 edge while enabled
        bus_write(4'd9, 32'h0000_0001);
        set_src(0, 1'b1);
        chk_irq("R3 irq on edge", 1'b1);
        bus_read(4'd8, 32'h0000_0001, "R3 R2 bank0 event bit0");

        // R5 ack semantics
        bus_write(4'd10, 32'h0);
        bus_read(4'd8, 32'h0000_0001, "R5 zero ack keeps event");
        bus_write(4'd10, 32'h0000_0001);
        chk_irq("R5 irq after ack", 1'b0);
        bus_read(4'd8, 32'h0, "R5 event cleared");

        // R4 enable with line already high
        set_src(1, 1'b1);
        bus_write(4'd9, 32'h0000_0003);
        chk_irq("R4 no request", 1'b0);
        bus_read(4'd8, 32'h0, "R4 no event");
        set_src(1, 1'b0);
        set_src(1, 1'b1);
        chk_irq("R3 fresh edge request", 1'b1);
        bus_read(4'd8, 32'h0000_0002, "R3 fresh edge event");
        bus_write(4'd10, 32'h0000_0002);

        // R7 level source bank0 bit20
        set_src(20, 1'b1);
        bus_write(4'd9, 32'h0010_0003);
        chk_irq("R7 level request", 1'b1);
        bus_read(4'd8, 32'h0, "R7 level no event");
        set_src(20, 1'b0);
        chk_irq("R7 level release", 1'b0);

        // R6 raw level readback
        bus_read(4'd11, 32'h0000_0003, "R6 bank0 level");
        bus_read(4'd7, 32'h0, "R6 bank1 level");

        // R2 R8 bank1 source 40
        bus_write(4'd5, 32'h0000_0100);
        set_src(40, 1'b1);
        chk_irq("R8 bank1 request", 1'b1);
        bus_read(4'd4, 32'h0000_0100, "R2 bank1 event bit8");
        bus_write(4'd5, 32'h0);
        chk_irq("R8 disable drops request", 1'b0);
        bus_read(4'd4, 32'h0000_0100, "R8 event retained");
        bus_write(4'd6, 32'h0000_0100);
        bus_read(4'd4, 32'h0, "R5 bank1 ack");

        // R7 bank1 level source 60
        bus_write(4'd5, 32'h1000_0000);
        set_src(60, 1'b1);
        chk_irq("R7 bank1 level request", 1'b1);
        bus_read(4'd7, 32'h1000_0100, "R6 bank1 raw lines");
        set_src(60, 1'b0);
        bus_write(4'd5, 32'h0);
        bus_write(4'd6, 32'h1000_0000);

        // R9 enable readback
        bus_write(4'd5, 32'hA5A5_5A5A);
        bus_read(4'd5, 32'hA5A5_5A5A, "R9 enable readback");
        bus_write(4'd5, 32'h0);

        // R10 ignored accesses
        bus_read(4'd0, 32'h0, "R10 unmapped low");
        bus_read(4'd12, 32'h0, "R10 unmapped high");
        bus_read(4'd10, 32'h0, "R10 ack reads zero");
        bus_write(4'd8, 32'hFFFF_FFFF);
        bus_read(4'd8, 32'h0, "R10 event write ignored");
        bus_write(4'd11, 32'hFFFF_FFFF);
        bus_read(4'd11, 32'h0000_0003, "R10 level write ignored");
        bus_write(4'd1, 32'hFFFF_FFFF);
        bus_read(4'd9, 32'h0010_0003, "R10 unmapped write ignored");

        // R5 new edge wins over its own ack
        bus_write(4'd9, 32'h0000_0008);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd10; bus_wdata = 32'h0000_0008; src[3] = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        bus_read(4'd8, 32'h0000_0008, "R5 set wins over ack");
        chk_irq("R5 request after collision", 1'b1);

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) check("R11 missing response", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule